// File: doc/BRIEF.md
# Key-Press Wake-Up Request Detector

This block monitors a small group of key lines and produces a single interrupt request when any participating line is pressed, that is, pulled from high to low. Each line has a direction bit. Only lines configured as inputs (bit at 0) take part. All participating lines are merged into one shared detection node that is low whenever any of them is low. As a result, once one key is held down, presses on the other keys are not seen until every participating key has been released.

The merged node is brought into the clock domain through a synchronizer. A high-to-low change of the synchronized node sets a sticky request flag. Firmware clears that flag by pulsing a clear strobe.

Separately, a wake-up output is derived combinationally from the raw merged node and gated by a sleep-mode input. This lets a key press bring the system out of a stopped-clock state. A single configuration bit drives the pull-up enable for the whole key group.

Top module: `keywake_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `dir_q` is 0, `pullup_en` is 0 and `key_req` is 0.
- R2: A cycle with `cfg_we` high loads `cfg_dir` into `dir_q` and `cfg_pull` into `pullup_en`, both visible after that clock edge.
- R3: A high-to-low change on any line whose `dir_q` bit is 0, while all other participating lines are high, sets `key_req` at the third rising clock edge after the change. The flag is still 0 after the second edge.
- R4: A line whose `dir_q` bit is 1 is ignored: it affects neither `key_req` nor `wake`.
- R5: While any participating line is low, falls on other participating lines produce no request.
- R6: `key_req` stays set until a cycle with `flag_clr` high, after which it reads 0.
- R7: When a detected fall and `flag_clr` fall on the same clock edge, `key_req` stays 1.
- R8: `wake` is high exactly when `sleep_mode` is high and at least one participating line is low. It is combinational, with no clock edge involved.
- R9: A change of `dir_q` that brings an already-low line into the group raises no request. Detection resumes once the merged node has been seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_pin | input | NUM_KEYS | Raw key line levels, low means pressed |
| sleep_mode | input | 1 | Allows `wake` to assert |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir | input | NUM_KEYS | Direction bits to write, 0 means input (participating) |
| cfg_pull | input | 1 | Group pull-up enable to write |
| flag_clr | input | 1 | Request flag clear strobe |
| dir_q | output | NUM_KEYS | Current direction bits |
| pullup_en | output | 1 | Group pull-up enable |
| key_req | output | 1 | Sticky interrupt request flag |
| wake | output | 1 | Asynchronous wake-up request |

## Verification
The assertions assume that the key lines are asynchronous but slow compared with the clock. They also assume that a direction change is issued as a single `cfg_we` cycle rather than a burst.

The stimulus holds every key pattern for at least five clock cycles and changes direction bits only between patterns. Because of this, every transition crosses the synchronizer cleanly, and the reference model can reason about the merged node one pattern at a time.

Directed cases cover the cases that are hard to hit by chance: a masked line, keys held together, a fall that coincides with a clear, and a low line that joins the group.

// File: rtl/keywake_pkg.sv
package keywake_pkg;
    localparam int KEYS        = 4;
    localparam int SYNC_STAGES = 2;

    typedef logic [KEYS-1:0] keymask_t;

    typedef struct packed {
        keymask_t dir;
        logic     pull;
    } kw_cfg_t;

    // merged node: high only when every participating line is high
    function automatic logic merge_node(input keymask_t pins, input keymask_t dir);
        return &(pins | dir);
    endfunction
endpackage

// File: rtl/kw_cfg_regs.sv
module kw_cfg_regs
    import keywake_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  kw_cfg_t  wdata,
    output kw_cfg_t  cfg,
    output logic     dir_change
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= wdata;
        end
    end

    assign dir_change = we && (wdata.dir != cfg.dir);
endmodule

// File: rtl/kw_node.sv
module kw_node
    import keywake_pkg::*;
(
    input  keymask_t pins,
    input  keymask_t dir,
    input  logic     sleep_mode,
    output logic     node,
    output logic     wake
);
    assign node = merge_node(pins, dir);
    assign wake = sleep_mode & ~node;
endmodule

// File: rtl/kw_fall_detect.sv
module kw_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic node_async,
    input  logic rearm,
    output logic fall
);
    localparam int HOLD_W = $clog2(STAGES + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(STAGES);

    logic [STAGES-1:0] chain;
    logic              sync_q;
    logic              prev_q;
    logic              armed;
    logic [HOLD_W-1:0] holdoff;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], node_async};
        end
    end
    assign sync_q = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            holdoff <= HOLD_LOAD;
            armed   <= 1'b0;
        end else begin
            if (holdoff != '0) begin
                holdoff <= holdoff - 1'b1;
            end
            if (holdoff == '0 && sync_q) begin
                armed <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= sync_q;
        end
    end

    assign fall = armed & prev_q & ~sync_q;

    // R5: one press yields a single detection pulse
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/keywake_top.sv
module keywake_top
    import keywake_pkg::*;
#(
    parameter int NUM_KEYS    = KEYS,
    parameter int SYNC_DEPTH  = SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] key_pin,
    input  logic                sleep_mode,
    input  logic                cfg_we,
    input  logic [NUM_KEYS-1:0] cfg_dir,
    input  logic                cfg_pull,
    input  logic                flag_clr,
    output logic [NUM_KEYS-1:0] dir_q,
    output logic                pullup_en,
    output logic                key_req,
    output logic                wake
);
    kw_cfg_t wcfg;
    kw_cfg_t cfg;
    logic    dir_change;
    logic    node;
    logic    fall;

    assign wcfg = '{dir: keymask_t'(cfg_dir), pull: cfg_pull};

    kw_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .wdata      (wcfg),
        .cfg        (cfg),
        .dir_change (dir_change)
    );

    kw_node u_node (
        .pins       (keymask_t'(key_pin)),
        .dir        (cfg.dir),
        .sleep_mode (sleep_mode),
        .node       (node),
        .wake       (wake)
    );

    kw_fall_detect #(.STAGES(SYNC_DEPTH)) u_fall (
        .clk        (clk),
        .rst        (rst),
        .node_async (node),
        .rearm      (dir_change),
        .fall       (fall)
    );

    // sticky request: a new fall wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            key_req <= 1'b0;
        end else if (fall) begin
            key_req <= 1'b1;
        end else if (flag_clr) begin
            key_req <= 1'b0;
        end
    end

    assign dir_q     = NUM_KEYS'(cfg.dir);
    assign pullup_en = cfg.pull;

    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == '0 && !pullup_en && !key_req));
    p_fall_sets_r3: assert property (@(posedge clk) disable iff (rst)
        fall |=> key_req);
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        key_req && !flag_clr |=> key_req);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        flag_clr && !fall |=> !key_req);
    p_fall_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        fall && flag_clr |=> key_req);
    p_no_req_on_join_r9: assert property (@(posedge clk) disable iff (rst)
        dir_change |=> !fall);
endmodule

// File: tb/tb_keywake_top.sv
`timescale 1ns/1ps
module tb_keywake_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] key_pin;
    logic         sleep_mode;
    logic         cfg_we;
    logic [N-1:0] cfg_dir;
    logic         cfg_pull;
    logic         flag_clr;
    logic [N-1:0] dir_q;
    logic         pullup_en;
    logic         key_req;
    logic         wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    keywake_top dut (
        .clk(clk), .rst(rst), .key_pin(key_pin), .sleep_mode(sleep_mode),
        .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_pull(cfg_pull),
        .flag_clr(flag_clr), .dir_q(dir_q), .pullup_en(pullup_en),
        .key_req(key_req), .wake(wake)
    );

    function automatic logic exp_node(input logic [N-1:0] p, input logic [N-1:0] d);
        return &(p | d);
    endfunction

    function automatic logic exp_wake(input logic [N-1:0] p, input logic [N-1:0] d,
                                      input logic s);
        return s & ~exp_node(p, d);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_cfg(input logic [N-1:0] d, input logic p);
        cfg_we = 1'b1; cfg_dir = d; cfg_pull = p;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [N-1:0] dir_m;
        logic         prev_n;
        void'($urandom(32'h1d5a7));
        rst = 1'b1; key_pin = '1; sleep_mode = 1'b0; cfg_we = 1'b0;
        cfg_dir = '0; cfg_pull = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        step(3);
        check("R1 dir", dir_q, 0);
        check("R1 pull", pullup_en, 0);
        check("R1 req", key_req, 0);
        rst = 1'b0;
        step(1);
        check("R1 req after release", key_req, 0);
        step(5);

        // R2: configuration write
        write_cfg(4'b1010, 1'b1);
        check("R2 dir", dir_q, 4'b1010);
        check("R2 pull", pullup_en, 1);
        write_cfg(4'b0000, 1'b0);
        check("R2 dir back", dir_q, 0);
        check("R2 pull back", pullup_en, 0);
        step(4);

        // R3: single press, latency of three edges
        key_pin = 4'b1110;
        step(2);
        check("R3 not yet", key_req, 0);
        step(1);
        check("R3 set", key_req, 1);

        // R8: wake is combinational
        sleep_mode = 1'b1; #1;
        check("R8 wake high", wake, 1);
        sleep_mode = 1'b0; #1;
        check("R8 wake gated", wake, 0);

        // R6: sticky then cleared
        step(3);
        check("R6 sticky", key_req, 1);
        clear_flag();
        check("R6 cleared", key_req, 0);

        // R5: second key while first is held
        key_pin = 4'b1100;
        step(5);
        check("R5 masked by held key", key_req, 0);
        key_pin = 4'b1111;
        step(5);
        check("R5 release", key_req, 0);

        // R7: fall coincides with clear
        key_pin = 4'b0111;
        step(2);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        check("R7 fall beats clear", key_req, 1);
        clear_flag();
        key_pin = 4'b1111;
        step(5);

        // R4: line configured as output is ignored
        write_cfg(4'b0100, 1'b0);
        step(5);
        key_pin = 4'b1011;
        step(5);
        check("R4 ignored req", key_req, 0);
        sleep_mode = 1'b1; #1;
        check("R4 ignored wake", wake, 0);
        sleep_mode = 1'b0;

        // R9: low line joins the group
        write_cfg(4'b0000, 1'b0);
        step(6);
        check("R9 no spurious req", key_req, 0);
        sleep_mode = 1'b1; #1;
        check("R8 wake after join", wake, 1);
        sleep_mode = 1'b0;
        key_pin = 4'b1111;
        step(5);
        check("R9 release", key_req, 0);
        key_pin = 4'b1011;
        step(3);
        check("R9 detection resumes", key_req, 1);
        clear_flag();
        key_pin = 4'b1111;
        step(5);

        // random phase
        dir_m = N'($urandom);
        write_cfg(dir_m, 1'b0);
        step(5);
        prev_n = exp_node(key_pin, dir_m);
        for (int it = 0; it < 200; it++) begin
            logic [N-1:0] nk;
            logic         sl;
            logic         nn;
            if (it % 25 == 24) begin
                dir_m = N'($urandom);
                write_cfg(dir_m, 1'b0);
                step(5);
                check("R9 random dir change", key_req, 0);
                prev_n = exp_node(key_pin, dir_m);
            end
            nk = N'($urandom);
            sl = 1'($urandom);
            key_pin = nk; sleep_mode = sl; #1;
            check("R8 random wake", wake, exp_wake(nk, dir_m, sl));
            step(4);
            nn = exp_node(nk, dir_m);
            check("R3/R5 random req", key_req, prev_n & ~nn);
            prev_n = nn;
            clear_flag();
            check("R6 random clear", key_req, 0);
        end
        finish_run();
    end
endmodule